// File: doc/BRIEF.md
# Bridge I/O Window Decoder

This block decides what happens to each I/O request that reaches a bridge between a PCI Express link and a PCI bus. For every request it gives one of three outcomes. The request can be passed on to the secondary bus. It can be master aborted. Or it can be flagged as an unsupported request because it targets one of the bridge's own internal functions.

The bridge has a single I/O window, and the window only passes traffic downstream. Its base and limit come from configuration registers. Their low address bits are filled in according to a granularity control, which selects either 4-KB or 1-KB alignment. Every I/O request that travels upstream is aborted. A downstream request is forwarded only when the command register's I/O enable is set and the address lies inside the window.

The decision is held in a small state machine with four states.
- ST_IDLE means no decision is being presented.
- ST_FWD, ST_ABORT and ST_UNSUP each present a decision for one cycle.

Each clock edge loads the outcome of the current request:
- TO_UNSUP is taken for an internal target.
- TO_ABORT_UP is taken for an upstream access.
- TO_ABORT_OFF is taken when I/O is disabled.
- TO_FWD is taken for a window hit.
- TO_ABORT_MISS is taken for a miss.
- TO_IDLE is taken when no request is valid.

Any state can move to any other state on the next edge.

Top module: `io_win_decoder`

## Requirements
- R1: `dec_valid` is high in the cycle after each cycle in which `req_valid` is high, and low in the cycle after each cycle in which `req_valid` is low.
- R2: While `dec_valid` is high, exactly one of `dec_forward`, `dec_abort` and `dec_unsupported` is high. While `dec_valid` is low, all three are low.
- R3: A request with `req_internal` = 1 is decided as unsupported, whatever its direction, address, enable or window settings.
- R4: A request with `req_upstream` = 1 and `req_internal` = 0 is master aborted, even when its address lies inside the window.
- R5: A downstream request with `cmd_io_en` = 0 is master aborted, even when its address lies inside the window.
- R6: A downstream request with `cmd_io_en` = 1 is forwarded when its address lies within the inclusive range from the effective base to the effective limit. Otherwise it is master aborted.
- R7: With `gran_1k` = 0, the effective base is `win_base` with its low 12 bits cleared. The effective limit is `win_limit` with its low 12 bits set.
- R8: With `gran_1k` = 1, the effective base is `win_base` with its low 10 bits cleared. The effective limit is `win_limit` with its low 10 bits set.
- R9: When the effective base is above the effective limit, the window is empty and every downstream request is master aborted.
- R10: While `rst_n` is low, and in the first cycle after it rises, `dec_valid`, `dec_forward`, `dec_abort` and `dec_unsupported` are all low.
- R11: Requests on consecutive cycles are each decided independently, one decision per cycle, in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An I/O request is present this cycle |
| req_upstream | input | 1 | 1 = request came from the PCI side, 0 = from the PCI Express side |
| req_internal | input | 1 | The request targets an internal bridge function |
| req_addr | input | ADDR_W | I/O address of the request |
| cmd_io_en | input | 1 | I/O enable bit of the command register |
| win_base | input | ADDR_W | I/O base register value |
| win_limit | input | ADDR_W | I/O limit register value |
| gran_1k | input | 1 | 1 selects 1-KB window granularity, 0 selects 4-KB |
| dec_valid | output | 1 | A decision is presented this cycle |
| dec_forward | output | 1 | Decision: forward to the secondary bus |
| dec_abort | output | 1 | Decision: master abort |
| dec_unsupported | output | 1 | Decision: unsupported request (internal target) |

## Verification
The decision for a request driven before clock edge k is due one edge later. It is visible from edge k until edge k+1. The driver applies each request at a falling edge and pushes the expected outcome into a queue. The monitor samples just after the following falling edge, so it reads each decision in the middle of the cycle it belongs to. The monitor pops one queued item for every cycle in which `dec_valid` is high. Because of this, a missing or extra decision shows up either as a wrong match or as a non-empty queue at the end. Idle-cycle and reset checks sample at the same mid-cycle point.

// File: rtl/io_win_pkg.sv
package io_win_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FWD   = 2'd1,
        ST_ABORT = 2'd2,
        ST_UNSUP = 2'd3
    } dec_state_e;

endpackage

// File: rtl/io_win_bounds.sv
module io_win_bounds #(
    parameter int ADDR_W      = 32,
    parameter int COARSE_BITS = 12,
    parameter int FINE_BITS   = 10
) (
    input  logic [ADDR_W-1:0] base_raw,
    input  logic [ADDR_W-1:0] limit_raw,
    input  logic              fine_gran,
    output logic [ADDR_W-1:0] base_eff,
    output logic [ADDR_W-1:0] limit_eff,
    output logic              win_empty
);

    localparam logic [ADDR_W-1:0] COARSE_MASK =
        {{(ADDR_W-COARSE_BITS){1'b0}}, {COARSE_BITS{1'b1}}};
    localparam logic [ADDR_W-1:0] FINE_MASK =
        {{(ADDR_W-FINE_BITS){1'b0}}, {FINE_BITS{1'b1}}};

    logic [ADDR_W-1:0] low_mask;

    always_comb begin
        low_mask  = fine_gran ? FINE_MASK : COARSE_MASK;
        base_eff  = base_raw & ~low_mask;
        limit_eff = limit_raw | low_mask;
        win_empty = (base_eff > limit_eff);
    end

endmodule

// File: rtl/io_win_match.sv
module io_win_match #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] lo_bound,
    input  logic [ADDR_W-1:0] hi_bound,
    output logic              in_window
);

    logic above_lo;
    logic below_hi;

    always_comb begin
        above_lo  = (addr >= lo_bound);
        below_hi  = (addr <= hi_bound);
        in_window = above_lo && below_hi;
    end

endmodule

// File: rtl/io_win_decoder.sv
module io_win_decoder
    import io_win_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int COARSE_BITS = 12,
    parameter int FINE_BITS   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_upstream,
    input  logic              req_internal,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              cmd_io_en,
    input  logic [ADDR_W-1:0] win_base,
    input  logic [ADDR_W-1:0] win_limit,
    input  logic              gran_1k,
    output logic              dec_valid,
    output logic              dec_forward,
    output logic              dec_abort,
    output logic              dec_unsupported
);

    logic [ADDR_W-1:0] base_eff;
    logic [ADDR_W-1:0] limit_eff;
    logic              win_empty;
    logic              addr_hit;

    dec_state_e state_q;
    dec_state_e state_d;

    io_win_bounds #(
        .ADDR_W      (ADDR_W),
        .COARSE_BITS (COARSE_BITS),
        .FINE_BITS   (FINE_BITS)
    ) u_bounds (
        .base_raw  (win_base),
        .limit_raw (win_limit),
        .fine_gran (gran_1k),
        .base_eff  (base_eff),
        .limit_eff (limit_eff),
        .win_empty (win_empty)
    );

    io_win_match #(
        .ADDR_W (ADDR_W)
    ) u_match (
        .addr      (req_addr),
        .lo_bound  (base_eff),
        .hi_bound  (limit_eff),
        .in_window (addr_hit)
    );

    // Transitions: TO_IDLE, TO_UNSUP, TO_ABORT_UP, TO_ABORT_OFF, TO_FWD, TO_ABORT_MISS
    always_comb begin
        if (!req_valid) begin
            state_d = ST_IDLE;
        end else if (req_internal) begin
            state_d = ST_UNSUP;
        end else if (req_upstream) begin
            state_d = ST_ABORT;
        end else if (!cmd_io_en) begin
            state_d = ST_ABORT;
        end else if (addr_hit) begin
            state_d = ST_FWD;
        end else begin
            state_d = ST_ABORT;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        dec_valid       = 1'b0;
        dec_forward     = 1'b0;
        dec_abort       = 1'b0;
        dec_unsupported = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_FWD: begin
                dec_valid   = 1'b1;
                dec_forward = 1'b1;
            end
            ST_ABORT: begin
                dec_valid = 1'b1;
                dec_abort = 1'b1;
            end
            ST_UNSUP: begin
                dec_valid       = 1'b1;
                dec_unsupported = 1'b1;
            end
        endcase
    end

    // R1
    a_r1_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> dec_valid);
    a_r1_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !dec_valid);
    // R2
    a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $countones({dec_forward, dec_abort, dec_unsupported}) == 1);
    a_r2_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !(dec_forward || dec_abort || dec_unsupported));
    // R3
    a_r3_internal_unsup: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_internal) |=> dec_unsupported);
    // R4
    a_r4_upstream_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_upstream && !req_internal) |=> dec_abort);
    // R5
    a_r5_disabled_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_upstream && !req_internal && !cmd_io_en) |=> dec_abort);
    // R9
    a_r9_empty_never_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && win_empty) |=> !dec_forward);
    // R10
    a_r10_reset_clears: assert property (@(posedge clk)
        !rst_n |=> !dec_valid);

endmodule

// File: tb/test_io_win_decoder.sv
module test_io_win_decoder;

    localparam int ADDR_W = 32;
    localparam int C_FWD   = 0;
    localparam int C_ABORT = 1;
    localparam int C_UNSUP = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_upstream = 1'b0;
    logic              req_internal = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              cmd_io_en = 1'b0;
    logic [ADDR_W-1:0] win_base = '0;
    logic [ADDR_W-1:0] win_limit = '0;
    logic              gran_1k = 1'b0;
    logic              dec_valid;
    logic              dec_forward;
    logic              dec_abort;
    logic              dec_unsupported;

    int checks = 0;
    int errors = 0;
    int    exp_q[$];
    string tag_q[$];

    io_win_decoder #(.ADDR_W(ADDR_W)) i_io_win_decoder (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid       (req_valid),
        .req_upstream    (req_upstream),
        .req_internal    (req_internal),
        .req_addr        (req_addr),
        .cmd_io_en       (cmd_io_en),
        .win_base        (win_base),
        .win_limit       (win_limit),
        .gran_1k         (gran_1k),
        .dec_valid       (dec_valid),
        .dec_forward     (dec_forward),
        .dec_abort       (dec_abort),
        .dec_unsupported (dec_unsupported)
    );

    always #10 clk = ~clk;

    function automatic int model(input logic up, input logic intl,
                                 input logic [ADDR_W-1:0] a, input logic en,
                                 input logic [ADDR_W-1:0] b, input logic [ADDR_W-1:0] l,
                                 input logic g);
        logic [ADDR_W-1:0] m;
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
        m  = g ? 32'h0000_03FF : 32'h0000_0FFF;
        lo = b & ~m;
        hi = l | m;
        if (intl) return C_UNSUP;
        if (up) return C_ABORT;
        if (!en) return C_ABORT;
        if (lo > hi) return C_ABORT;
        if (a >= lo && a <= hi) return C_FWD;
        return C_ABORT;
    endfunction

    task automatic send(input string tag, input logic up, input logic intl,
                        input logic [ADDR_W-1:0] a, input logic en,
                        input logic [ADDR_W-1:0] b, input logic [ADDR_W-1:0] l,
                        input logic g);
        @(negedge clk);
        req_valid    = 1'b1;
        req_upstream = up;
        req_internal = intl;
        req_addr     = a;
        cmd_io_en    = en;
        win_base     = b;
        win_limit    = l;
        gran_1k      = g;
        exp_q.push_back(model(up, intl, a, en, b, l, g));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    task automatic check_quiet(input string tag);
        checks++;
        if (dec_valid || dec_forward || dec_abort || dec_unsupported) begin
            errors++;
            $display("FAIL %s: outputs v/f/a/u=%b%b%b%b expected 0000", tag,
                     dec_valid, dec_forward, dec_abort, dec_unsupported);
        end
    endtask

    // Monitor: scoreboard compare (R2, R11)
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && dec_valid) begin
                int    e;
                string t;
                int    got;
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R1: unexpected decision, actual valid=1 expected none");
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    got = (dec_forward && !dec_abort && !dec_unsupported) ? C_FWD :
                          (!dec_forward && dec_abort && !dec_unsupported) ? C_ABORT :
                          (!dec_forward && !dec_abort && dec_unsupported) ? C_UNSUP : 9;
                    if (got != e) begin
                        errors++;
                        $display("FAIL %s (R2): actual code %0d (f/a/u=%b%b%b) expected %0d",
                                 t, got, dec_forward, dec_abort, dec_unsupported, e);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        #1;
        check_quiet("R10 during reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check_quiet("R10 after reset");

        // R7: 4-KB granularity, window 0x1000..0x2FFF
        send("R7 base edge fwd",     0, 0, 32'h1000, 1, 32'h1234, 32'h2000, 0);
        send("R7 limit edge fwd",    0, 0, 32'h2FFF, 1, 32'h1234, 32'h2000, 0);
        send("R6 above limit abort", 0, 0, 32'h3000, 1, 32'h1234, 32'h2000, 0);
        send("R6 below base abort",  0, 0, 32'h0FFF, 1, 32'h1234, 32'h2000, 0);
        idle(2);
        #1;
        check_quiet("R1 idle no decision");

        // R8: 1-KB granularity, window 0x1400..0x1BFF
        send("R8 below base abort",  0, 0, 32'h13FF, 1, 32'h1400, 32'h1800, 1);
        send("R8 base edge fwd",     0, 0, 32'h1400, 1, 32'h1400, 32'h1800, 1);
        send("R8 limit edge fwd",    0, 0, 32'h1BFF, 1, 32'h1400, 32'h1800, 1);
        send("R8 above limit abort", 0, 0, 32'h1C00, 1, 32'h1400, 32'h1800, 1);
        // R7: same registers with 4-KB alignment widen to 0x1000..0x1FFF
        send("R7 widened low fwd",   0, 0, 32'h13FF, 1, 32'h1400, 32'h1800, 0);
        send("R7 widened high fwd",  0, 0, 32'h1C00, 1, 32'h1400, 32'h1800, 0);
        idle(1);

        // R9: empty window
        send("R9 empty abort",       0, 0, 32'h2800, 1, 32'h3000, 32'h2000, 0);
        send("R9 empty 1k abort",    0, 0, 32'h1500, 1, 32'h1800, 32'h1000, 1);
        send("R7 same granule fwd",  0, 0, 32'h1500, 1, 32'h1800, 32'h1000, 0);
        idle(1);

        // R5, R4, R3
        send("R5 disabled abort",    0, 0, 32'h1800, 0, 32'h1000, 32'h2000, 0);
        send("R4 upstream abort",    1, 0, 32'h1800, 1, 32'h1000, 32'h2000, 0);
        send("R4 upstream out abort",1, 0, 32'h8000, 1, 32'h1000, 32'h2000, 0);
        send("R3 internal down",     0, 1, 32'h1800, 1, 32'h1000, 32'h2000, 0);
        send("R3 internal up off",   1, 1, 32'h9000, 0, 32'h3000, 32'h2000, 1);
        send("R6 control fwd",       0, 0, 32'h1800, 1, 32'h1000, 32'h2000, 0);

        // R11: long back-to-back run alternating outcomes
        for (int i = 0; i < 12; i++) begin
            send("R11 burst", i[0], (i % 3) == 2, 32'h1000 + i * 32'h0400, 1,
                 32'h1000, 32'h2000, 1);
        end
        idle(3);
        #1;
        check_quiet("R1 drained idle");

        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R1: %0d decisions missing, expected 0", exp_q.size());
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule